// File: doc/BRIEF.md
# Mixed Page-Size Translation Cache

This block caches recent virtual-to-physical translations in a small, fully associative table. Each slot records the aligned virtual page base, the aligned physical page base, a page-size code and six attribute bits. A lookup is combinational. The block compares the presented virtual address against every valid slot. On a hit it returns the physical address, built by merging the slot's physical base with the in-page offset, together with the slot's attributes.

A page walker writes completed translations through the insert port. A new translation goes into the lowest-numbered empty slot. When no slot is empty, it replaces the least recently used one. Two flush commands clear the table. One clears every slot. The other clears only the slots whose global attribute is clear. If two slots ever matched the same address, the lowest-numbered slot would win. The walker is expected never to create that case.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, `lk_attr` returns the attributes stored with the slot. The bit order is 0 writable, 1 user, 2 no-execute, 3 uncacheable, 4 global, 5 PAT-select. On a miss, `lk_attr` and `lk_paddr` are zero.
- R2: After reset every slot is empty, and every lookup misses.
- R3: On a hit, `lk_paddr` equals the slot's physical base OR'd with `lk_vaddr & (page size - 1)`. The size codes are 0 = 4 KB, 1 = 2 MB and 2 = 4 MB. Code 3 is handled as 4 KB.
- R4: A slot matches only when the address bits at and above log2(page size) equal its stored virtual base. An address one byte below the page, or one byte past its end, misses.
- R5: On insert, both the virtual base and the physical base are aligned down to the page size before they are stored.
- R6: While any slot is empty, an insert fills an empty slot and evicts no valid translation.
- R7: With every slot valid, an insert replaces the least recently used slot. A lookup hit (with `lk_req` high) and an insert each make the slot they touch the most recently used.
- R8: `flush_all` empties every slot, effective from the next cycle.
- R9: `flush_local` empties only the slots whose global attribute is 0. Global slots keep working.
- R10: A flush in the same cycle as `ins_en` wins, and the insert is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup is real; a hit updates recency |
| lk_vaddr | input | ADDR_W | Virtual address to translate |
| lk_hit | output | 1 | A valid slot matches |
| lk_paddr | output | ADDR_W | Translated physical address |
| lk_attr | output | 6 | Attributes of the matching slot |
| ins_en | input | 1 | Write a new translation |
| ins_vaddr | input | ADDR_W | Virtual address inside the new page |
| ins_paddr | input | ADDR_W | Physical address inside the new page |
| ins_size | input | 2 | Page-size code |
| ins_attr | input | 6 | Attributes of the new translation |
| flush_all | input | 1 | Empty all slots |
| flush_local | input | 1 | Empty all non-global slots |

## Verification
Offset sweeps run across one page of each size. Because the expected address is computed from the base and the offset, a wrong offset mask or a wrong size decode shows up as a changed address bit. Probes one byte either side of each page separate the tag-compare width from the offset width.

A fill-then-overflow sequence uses a known touch order, so the bench can name the exact slot that must be evicted each time. This separates true least-recently-used replacement from a fixed-slot or round-robin choice. Mixed global and local entries, and flushes issued together with an insert, show which slots each flush removes and that a flush wins over an insert.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_4M  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  localparam int ATTR_W      = 6;
  localparam int ATTR_WRITE  = 0;
  localparam int ATTR_USER   = 1;
  localparam int ATTR_NOEXEC = 2;
  localparam int ATTR_UNCACH = 3;
  localparam int ATTR_GLOBAL = 4;
  localparam int ATTR_PAT    = 5;

  // In-page offset mask for a size code; the reserved code behaves as 4 KB.
  function automatic logic [63:0] page_off_mask(pg_size_e s);
    case (s)
      PG_2M:   return 64'h0000_0000_001F_FFFF;
      PG_4M:   return 64'h0000_0000_003F_FFFF;
      default: return 64'h0000_0000_0000_0FFF;
    endcase
  endfunction

endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp
  import tlb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] vbase,
  input  pg_size_e          size,
  input  logic [ADDR_W-1:0] vaddr,
  output logic              hit
);
  logic [ADDR_W-1:0] off_m;
  assign off_m = ADDR_W'(page_off_mask(size));
  assign hit   = valid && ((vaddr & ~off_m) == vbase);
endmodule

// File: rtl/tlb_lru_order.sv
module tlb_lru_order #(
  parameter int ENTRIES = 8,
  parameter int IW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  // rank 0 = most recent, ENTRIES-1 = oldest; ranks form a permutation.
  logic [IW-1:0] rank_q [ENTRIES];
  logic [IW-1:0] touched_rank;

  assign touched_rank = rank_q[touch_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rank_q[g] <= IW'(g);
      end else if (touch_en) begin
        if (touch_idx == IW'(g))
          rank_q[g] <= '0;
        else if (rank_q[g] < touched_rank)
          rank_q[g] <= rank_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rank_q[i] == IW'(ENTRIES - 1)) victim_idx = IW'(i);
  end

  // R7: a touched slot becomes the most recent one
  a_r7_touch_mru: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> rank_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
  parameter int ENTRIES = 8,
  parameter int IW      = 3
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [IW-1:0]      victim_idx,
  output logic [IW-1:0]      slot,
  output logic               full
);
  logic [IW-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) free_idx = IW'(i);
  end

  assign full = &valid;
  assign slot = full ? victim_idx : free_idx;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import tlb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_vaddr,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_paddr,
  output logic [5:0]        lk_attr,
  input  logic              ins_en,
  input  logic [ADDR_W-1:0] ins_vaddr,
  input  logic [ADDR_W-1:0] ins_paddr,
  input  logic [1:0]        ins_size,
  input  logic [5:0]        ins_attr,
  input  logic              flush_all,
  input  logic              flush_local
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [ADDR_W-1:0] off_of(pg_size_e s);
    return ADDR_W'(page_off_mask(s));
  endfunction

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  vbase_q [ENTRIES];
  logic [ADDR_W-1:0]  pbase_q [ENTRIES];
  pg_size_e           size_q  [ENTRIES];
  logic [ATTR_W-1:0]  attr_q  [ENTRIES];

  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] glob_vec;
  logic               hit_any;
  logic [IW-1:0]      hit_idx;
  logic [IW-1:0]      victim_idx;
  logic [IW-1:0]      ins_slot;
  logic               table_full;
  logic               flush_any;
  logic               ins_commit;
  logic               touch_en;
  logic [IW-1:0]      touch_idx;
  pg_size_e           ins_sz;
  logic [ADDR_W-1:0]  ins_off;

  // Per-slot comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_tag_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .valid (valid_q[g]),
      .vbase (vbase_q[g]),
      .size  (size_q[g]),
      .vaddr (lk_vaddr),
      .hit   (match_vec[g])
    );
    assign glob_vec[g] = attr_q[g][ATTR_GLOBAL];
  end

  // Lowest-index match wins
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match_vec[i]) begin
        hit_any = 1'b1;
        hit_idx = IW'(i);
      end
  end

  assign lk_hit   = hit_any;
  assign lk_paddr = hit_any ? (pbase_q[hit_idx] | (lk_vaddr & off_of(size_q[hit_idx]))) : '0;
  assign lk_attr  = hit_any ? attr_q[hit_idx] : '0;

  // Control events
  assign flush_any  = flush_all | flush_local;
  assign ins_commit = ins_en & ~flush_any;
  assign touch_en   = ~flush_any & (ins_en | (lk_req & hit_any));
  assign touch_idx  = ins_en ? ins_slot : hit_idx;
  assign ins_sz     = pg_size_e'(ins_size);
  assign ins_off    = off_of(ins_sz);

  tlb_lru_order #(.ENTRIES(ENTRIES), .IW(IW)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  tlb_slot_pick #(.ENTRIES(ENTRIES), .IW(IW)) u_pick (
    .valid      (valid_q),
    .victim_idx (victim_idx),
    .slot       (ins_slot),
    .full       (table_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      valid_q <= '0;
    else if (flush_all)
      valid_q <= '0;
    else if (flush_local)
      valid_q <= valid_q & glob_vec;
    else if (ins_en)
      valid_q[ins_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ins_commit) begin
      vbase_q[ins_slot] <= ins_vaddr & ~ins_off;
      pbase_q[ins_slot] <= ins_paddr & ~ins_off;
      size_q[ins_slot]  <= ins_sz;
      attr_q[ins_slot]  <= ins_attr;
    end
  end

  // R8: a full flush leaves nothing valid
  a_r8_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_q == '0);

  // R9: selective flush keeps exactly the global slots
  a_r9_keep_global: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_local && !flush_all) |=> valid_q == ($past(valid_q) & $past(glob_vec)));

  // R10: an insert beside a flush adds no valid slot
  a_r10_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && flush_any) |=> $countones(valid_q) <= $countones($past(valid_q)));

  // R6: with a free slot, an insert grows the valid count by one
  a_r6_fill_free: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_commit && !table_full) |=> $countones(valid_q) == $countones($past(valid_q)) + 1);

  // R7: once full, replacement keeps the table full
  a_r7_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_commit && table_full) |=> &valid_q);

  // R4: a reported hit is backed by a valid slot
  a_r4_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid_q & match_vec) != '0);
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_req = 1'b0;
  logic [AW-1:0] lk_vaddr = '0;
  logic          lk_hit;
  logic [AW-1:0] lk_paddr;
  logic [5:0]    lk_attr;
  logic          ins_en = 1'b0;
  logic [AW-1:0] ins_vaddr = '0;
  logic [AW-1:0] ins_paddr = '0;
  logic [1:0]    ins_size = '0;
  logic [5:0]    ins_attr = '0;
  logic          flush_all = 1'b0;
  logic          flush_local = 1'b0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_cache #(.ADDR_W(AW), .ENTRIES(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_attr(lk_attr),
    .ins_en(ins_en), .ins_vaddr(ins_vaddr), .ins_paddr(ins_paddr),
    .ins_size(ins_size), .ins_attr(ins_attr),
    .flush_all(flush_all), .flush_local(flush_local)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [AW-1:0] va, output logic h,
                      output logic [AW-1:0] pa, output logic [5:0] at);
    lk_vaddr = va;
    lk_req   = 1'b1;
    #1;
    h  = lk_hit;
    pa = lk_paddr;
    at = lk_attr;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [AW-1:0] va, input logic [AW-1:0] pa_exp);
    logic h; logic [AW-1:0] pa; logic [5:0] at;
    look(va, h, pa, at);
    chk(tag, {63'd0, h}, 64'd1);
    chk(tag, {32'd0, pa}, {32'd0, pa_exp});
  endtask

  task automatic expect_miss(input string tag, input logic [AW-1:0] va);
    logic h; logic [AW-1:0] pa; logic [5:0] at;
    look(va, h, pa, at);
    chk(tag, {63'd0, h}, 64'd0);
    chk(tag, {32'd0, pa}, 64'd0);
  endtask

  task automatic expect_attr(input string tag, input logic [AW-1:0] va, input logic [5:0] at_exp);
    logic h; logic [AW-1:0] pa; logic [5:0] at;
    look(va, h, pa, at);
    chk(tag, {58'd0, at}, {58'd0, at_exp});
  endtask

  task automatic put(input logic [AW-1:0] va, input logic [AW-1:0] pa,
                     input logic [1:0] sz, input logic [5:0] at);
    ins_en = 1'b1; ins_vaddr = va; ins_paddr = pa; ins_size = sz; ins_attr = at;
    @(negedge clk);
    ins_en = 1'b0;
  endtask

  task automatic flush(input logic all, input logic local_only);
    flush_all = all; flush_local = local_only;
    @(negedge clk);
    flush_all = 1'b0; flush_local = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: empty after reset
    expect_miss("R2 reset empty lo", 32'h0000_0000);
    expect_miss("R2 reset empty hi", 32'h1234_5000);

    // Populate mixed sizes
    put(32'h1000_0000, 32'h8000_0000, 2'd0, 6'b000011);
    put(32'h0A00_0000, 32'h2020_0000, 2'd1, 6'b010100);
    put(32'h0C00_0000, 32'h4000_0000, 2'd2, 6'b101000);
    put(32'h1234_5678, 32'h0055_5ABC, 2'd0, 6'b000001);
    put(32'h0B00_0000, 32'h0600_0000, 2'd3, 6'b010000);

    // R3: offset sweeps per size
    for (int k = 0; k < 16; k++) begin
      expect_hit("R3 4K sweep", 32'h1000_0000 + k * 32'h0FF, 32'h8000_0000 + k * 32'h0FF);
      expect_hit("R3 2M sweep", 32'h0A00_0000 + k * 32'h1FFFF, 32'h2020_0000 + k * 32'h1FFFF);
      expect_hit("R3 4M sweep", 32'h0C00_0000 + k * 32'h3FFFF, 32'h4000_0000 + k * 32'h3FFFF);
    end
    expect_hit("R3 2M top", 32'h0A1F_FFFF, 32'h203F_FFFF);
    expect_hit("R3 4M top", 32'h0C3F_FFFF, 32'h403F_FFFF);

    // R4: page edges
    expect_miss("R4 4K past end", 32'h1000_1000);
    expect_miss("R4 4K below",    32'h0FFF_FFFF);
    expect_miss("R4 2M past end", 32'h0A20_0000);
    expect_miss("R4 2M below",    32'h09FF_FFFF);
    expect_miss("R4 4M past end", 32'h0C40_0000);
    expect_miss("R4 4M below",    32'h0BFF_FFFF);

    // R3: reserved size code acts as 4 KB
    expect_hit("R3 code3 in",  32'h0B00_0FFF, 32'h0600_0FFF);
    expect_miss("R3 code3 out", 32'h0B00_1000);

    // R5: alignment of both bases
    expect_hit("R5 align base", 32'h1234_5000, 32'h0055_5000);
    expect_hit("R5 align top",  32'h1234_5FFF, 32'h0055_5FFF);

    // R1: attributes
    expect_attr("R1 attr 4K", 32'h1000_0010, 6'b000011);
    expect_attr("R1 attr 2M", 32'h0A00_0010, 6'b010100);
    expect_attr("R1 attr 4M", 32'h0C00_0010, 6'b101000);
    expect_attr("R1 attr miss", 32'h7000_0000, 6'b000000);

    // R9: selective flush
    flush(1'b0, 1'b1);
    expect_miss("R9 local gone 4K", 32'h1000_0000);
    expect_miss("R9 local gone 4M", 32'h0C00_0000);
    expect_miss("R9 local gone unal", 32'h1234_5000);
    expect_hit("R9 global kept 2M", 32'h0A00_1234, 32'h2020_1234);
    expect_hit("R9 global kept c3", 32'h0B00_0004, 32'h0600_0004);

    // R8: full flush
    flush(1'b1, 1'b0);
    expect_miss("R8 all gone 2M", 32'h0A00_1234);
    expect_miss("R8 all gone c3", 32'h0B00_0004);

    // R10: flush beats insert
    flush_all = 1'b1;
    put(32'h3000_0000, 32'h5000_0000, 2'd0, 6'b000000);
    flush_all = 1'b0;
    expect_miss("R10 insert dropped by flush_all", 32'h3000_0000);
    flush_local = 1'b1;
    put(32'h3100_0000, 32'h5100_0000, 2'd0, 6'b010000);
    flush_local = 1'b0;
    expect_miss("R10 insert dropped by flush_local", 32'h3100_0000);

    // R6: fill eight slots, nothing evicted
    for (int i = 0; i < 8; i++)
      put(32'h2000_0000 + i * 32'h1000, 32'h9000_0000 + i * 32'h1000, 2'd0, 6'b000000);
    for (int i = 1; i < 8; i++)
      expect_hit("R6 fill kept", 32'h2000_0000 + i * 32'h1000, 32'h9000_0000 + i * 32'h1000);
    expect_hit("R6 fill kept first", 32'h2000_0000, 32'h9000_0000);

    // R7: oldest is slot holding page 1
    put(32'h2000_8000, 32'h9000_8000, 2'd0, 6'b000000);
    expect_miss("R7 oldest evicted", 32'h2000_1000);
    expect_hit("R7 new present", 32'h2000_8000, 32'h9000_8000);
    expect_hit("R7 touched kept", 32'h2000_0000, 32'h9000_0000);
    put(32'h2000_9000, 32'h9000_9000, 2'd0, 6'b000000);
    expect_miss("R7 next oldest evicted", 32'h2000_2000);
    expect_hit("R7 second new", 32'h2000_9000, 32'h9000_9000);
    for (int i = 3; i < 8; i++)
      expect_hit("R7 others kept", 32'h2000_0000 + i * 32'h1000, 32'h9000_0000 + i * 32'h1000);
    expect_hit("R7 recent kept", 32'h2000_8000, 32'h9000_8000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule